// File: doc/BRIEF.md
# Bus Clock Frequency Calibrator

This block estimates the rate of a bus clock whose frequency is not known in advance. It observes a square wave produced from that bus clock, where one full wave period is a fixed power-of-two number of bus ticks. It times that wave against its own clock, the reference clock, whose rate is a parameter. A start pulse arms a measurement. The wave passes through a two-flop synchroniser and only its rising edges are counted. The first few edges are skipped. Reference ticks are then accumulated over a power-of-two number of complete wave periods.

The accumulated count is shifted right by a constant to give a period per bus tick. The period is in reference ticks with `FRAC_BITS` fraction bits kept. It is compared against two precomputed bounds that correspond to the slowest and fastest acceptable bus frequencies. A value inside the bounds is published. A value outside them is replaced by the period of a default frequency and flags a failure. A missing wave is also caught, by a no-edge timeout that takes the default path.

The result is reported with a one-cycle done pulse and a fail flag that stays set until the next start. Software or a sequencer reads the period and uses it to scale timer and baud settings that derive from the bus clock.

Top module: `calib_top`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are 0 and `period` is 0.
- R2: A `start` pulse restarts the measurement from any state. In the following cycle `busy` is 1, and `done` and `fail` are 0.
- R3: Only a low-to-high transition of the synchronised wave counts as an edge. A wave that is already high when `start` arrives produces no edge until it has gone low and then risen again.
- R4: The first `DISCARD` rising edges are skipped. Timing runs from rising edge number `DISCARD` to rising edge number `DISCARD + 2**CYC_LOG2`, which covers exactly `2**CYC_LOG2` wave periods.
- R5: The measured period equals the elapsed reference ticks shifted right by `CYC_LOG2 + WAVE_LOG2 - FRAC_BITS`. This is reference ticks per bus tick with `FRAC_BITS` fraction bits.
- R6: A measured period that is at least the fast limit (`REF_HZ*2**FRAC_BITS/(HIGH_MHZ*1e6)`) and at most the slow limit (`REF_HZ*2**FRAC_BITS/(LOW_MHZ*1e6)`) is published, with `fail` = 0. Both bounds are inclusive.
- R7: A measured period above the slow limit or below the fast limit publishes the default period `REF_HZ*2**FRAC_BITS/(DEF_MHZ*1e6)`, with `fail` = 1.
- R8: `done` is high for exactly one cycle when a measurement ends, and `busy` is 0 in that cycle.
- R9: With `TIMEOUT` > 0, if no rising edge arrives for `TIMEOUT` reference cycles, the run ends. `done` rises `TIMEOUT` cycles after the cycle in which `start` was sampled (or after the last edge), with `fail` = 1 and the default period.
- R10: While idle and without `start`, `fail` and `period` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that arms a measurement |
| sqWave | input | 1 | Square wave derived from the bus clock (asynchronous) |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sticky: last result was out of range or timed out |
| period | output | PERIOD_W | Reference ticks per bus tick, FRAC_BITS fraction bits |

## Verification
The checker follows the handshake on every cycle:
- `done` lasts a single cycle and never coincides with `busy`.
- A start always re-arms the block and clears `fail`.
- A failing result always carries the default period, and a passing result always lies within the two bounds.
- Results hold steady while the block is idle.

The exact numeric period cannot be seen by a property, because it depends on the wave the bench drives. The same applies to the skipping of the first edges, the inclusive treatment of both bounds, a level that is already high at start, and the exact cycle a timeout fires. The directed scenarios cover these by driving waves of known half-period and comparing `period` with the value worked out from the wave.

// File: rtl/calib_pkg.sv
package calib_pkg;

  // Strobes issued by the control unit to the datapath
  typedef struct packed {
    logic clearAll;      // start: reset history, fail, arm
    logic markStart;     // edge DISCARD seen: zero the elapsed timer
    logic finishMeas;    // final edge seen: evaluate and publish
    logic finishTimeout; // edge gap expired: publish default
  } calStrobe_t;

  // Period in reference ticks per bus tick (fixed point) for a bus frequency in MHz
  function automatic longint limitTicks(longint refHz, int fracBits, int mhz);
    return (refHz <<< fracBits) / (longint'(mhz) * 64'sd1000000);
  endfunction

endpackage

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
#(
  parameter int CYC_LOG2 = 8,
  parameter int DISCARD  = 2,
  parameter int TIMEOUT  = 1 << 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rise,
  output logic       busy,
  output calStrobe_t strobe
);

  localparam int END_CNT = DISCARD + (1 << CYC_LOG2);
  localparam int EDGE_W  = $clog2(END_CNT + 1);

  logic              running;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeNext;
  logic              toHit;

  assign edgeNext = edgeCnt + 1'b1;
  assign busy     = running;

  always_comb begin
    strobe               = '0;
    strobe.clearAll      = start;
    strobe.markStart     = !start && running && rise && (edgeNext == EDGE_W'(DISCARD));
    strobe.finishMeas    = !start && running && rise && (edgeNext == EDGE_W'(END_CNT));
    strobe.finishTimeout = !start && running && !rise && toHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      edgeCnt <= '0;
    end else if (start) begin
      running <= 1'b1;
      edgeCnt <= '0;
    end else if (running) begin
      if (strobe.finishMeas || strobe.finishTimeout) running <= 1'b0;
      else if (rise) edgeCnt <= edgeNext;
    end
  end

  // Optional no-edge watchdog
  generate
    if (TIMEOUT > 0) begin : g_timeout
      localparam int TO_W = $clog2(TIMEOUT + 1);
      logic [TO_W-1:0] toCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) toCnt <= '0;
        else if (start || rise) toCnt <= '0;
        else if (running) toCnt <= toCnt + 1'b1;
      end
      assign toHit = (toCnt == TO_W'(TIMEOUT - 1));
    end else begin : g_no_timeout
      assign toHit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/calib_dp.sv
module calib_dp
  import calib_pkg::*;
#(
  parameter int     ELAPSED_W = 32,
  parameter int     PERIOD_W  = 25,
  parameter int     SHIFT     = 7,
  parameter longint SLOW_LIM  = 1024,
  parameter longint FAST_LIM  = 341,
  parameter longint DEF_PER   = 387
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sqWave,
  input  calStrobe_t          strobe,
  output logic                rise,
  output logic                done,
  output logic                fail,
  output logic [PERIOD_W-1:0] period
);

  localparam logic [PERIOD_W-1:0] SLOW_P = PERIOD_W'(SLOW_LIM);
  localparam logic [PERIOD_W-1:0] FAST_P = PERIOD_W'(FAST_LIM);
  localparam logic [PERIOD_W-1:0] DEF_P  = PERIOD_W'(DEF_PER);

  logic                 syncA, syncB, hist;
  logic [ELAPSED_W-1:0] timer, timerInc;
  logic [PERIOD_W-1:0]  measured;
  logic                 inRange;

  // Two-flop synchroniser and rising-edge detect; history starts high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      hist  <= 1'b1;
    end else begin
      syncA <= sqWave;
      syncB <= syncA;
      hist  <= strobe.clearAll ? 1'b1 : syncB;
    end
  end

  assign rise = syncB && !hist;

  // Elapsed reference ticks, saturating
  assign timerInc = (timer == '1) ? timer : timer + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timer <= '0;
    else if (strobe.markStart) timer <= '0;
    else timer <= timerInc;
  end

  assign measured = PERIOD_W'(timerInc >> SHIFT);
  assign inRange  = (measured >= FAST_P) && (measured <= SLOW_P);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done   <= 1'b0;
      fail   <= 1'b0;
      period <= '0;
    end else begin
      done <= strobe.finishMeas || strobe.finishTimeout;
      if (strobe.clearAll) begin
        fail <= 1'b0;
      end else if (strobe.finishMeas) begin
        fail   <= !inRange;
        period <= inRange ? measured : DEF_P;
      end else if (strobe.finishTimeout) begin
        fail   <= 1'b1;
        period <= DEF_P;
      end
    end
  end

endmodule

// File: rtl/calib_top.sv
module calib_top
  import calib_pkg::*;
#(
  parameter longint REF_HZ    = 100_000_000,
  parameter int     CYC_LOG2  = 8,
  parameter int     WAVE_LOG2 = 7,
  parameter int     DISCARD   = 2,
  parameter int     FRAC_BITS = 8,
  parameter int     LOW_MHZ   = 25,
  parameter int     HIGH_MHZ  = 75,
  parameter int     DEF_MHZ   = 66,
  parameter int     TIMEOUT   = 1 << 20,
  parameter int     ELAPSED_W = 32,
  localparam int    SHIFT     = CYC_LOG2 + WAVE_LOG2 - FRAC_BITS,
  localparam int    PERIOD_W  = ELAPSED_W - SHIFT
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                sqWave,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [PERIOD_W-1:0] period
);

  localparam longint SLOW_LIM = limitTicks(REF_HZ, FRAC_BITS, LOW_MHZ);
  localparam longint FAST_LIM = limitTicks(REF_HZ, FRAC_BITS, HIGH_MHZ);
  localparam longint DEF_PER  = limitTicks(REF_HZ, FRAC_BITS, DEF_MHZ);

  calStrobe_t strobe;
  logic       rise;

  calib_ctrl #(
    .CYC_LOG2(CYC_LOG2),
    .DISCARD (DISCARD),
    .TIMEOUT (TIMEOUT)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .rise  (rise),
    .busy  (busy),
    .strobe(strobe)
  );

  calib_dp #(
    .ELAPSED_W(ELAPSED_W),
    .PERIOD_W (PERIOD_W),
    .SHIFT    (SHIFT),
    .SLOW_LIM (SLOW_LIM),
    .FAST_LIM (FAST_LIM),
    .DEF_PER  (DEF_PER)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .sqWave(sqWave),
    .strobe(strobe),
    .rise  (rise),
    .done  (done),
    .fail  (fail),
    .period(period)
  );

endmodule

// File: rtl/calib_chk.sv
module calib_chk #(
  parameter int     PERIOD_W = 25,
  parameter longint SLOW_LIM = 1024,
  parameter longint FAST_LIM = 341,
  parameter longint DEF_PER  = 387
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                fail,
  input logic [PERIOD_W-1:0] period
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R8
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN) start |=> (busy && !fail && !done)); // R2
  AST_FAIL_DEFAULT: assert property (@(posedge clk) disable iff (!rstN) (done && fail) |-> (longint'(period) == DEF_PER)); // R7
  AST_PASS_BOUNDS: assert property (@(posedge clk) disable iff (!rstN) (done && !fail) |-> (longint'(period) >= FAST_LIM && longint'(period) <= SLOW_LIM)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN) (!start && !busy) |=> ($stable(fail) && $stable(period))); // R10

endmodule

bind calib_top calib_chk #(
  .PERIOD_W(PERIOD_W),
  .SLOW_LIM(SLOW_LIM),
  .FAST_LIM(FAST_LIM),
  .DEF_PER (DEF_PER)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .fail  (fail),
  .period(period)
);

// File: tb/calib_top_bench.sv
`timescale 1ns/1ps
module calib_top_bench;

  // Bench parameters: 8-cycle window, 4 bus ticks per wave, 4 fraction bits
  // Limits: slow = 200e6*16/25e6 = 128, fast = 3200/75 = 42, default = 3200/66 = 48
  localparam int EXP_SLOW = 128;
  localparam int EXP_DEF  = 48;
  localparam int TO_CYC   = 100;
  localparam int PW       = 16 - 1; // ELAPSED_W - SHIFT

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          sqWave = 1'b0;
  logic          busy, done, fail;
  logic [PW-1:0] period;

  logic waveOn = 1'b0;
  logic waveLevel = 1'b0;
  int   halfPer = 8;
  int   halfCnt = 0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  calib_top #(
    .REF_HZ   (200_000_000),
    .CYC_LOG2 (3),
    .WAVE_LOG2(2),
    .DISCARD  (2),
    .FRAC_BITS(4),
    .LOW_MHZ  (25),
    .HIGH_MHZ (75),
    .DEF_MHZ  (66),
    .TIMEOUT  (TO_CYC),
    .ELAPSED_W(16)
  ) u_calib_top (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .sqWave(sqWave),
    .busy  (busy),
    .done  (done),
    .fail  (fail),
    .period(period)
  );

  // Square wave, half period halfPer reference cycles, changed away from the active edge
  always @(negedge clk) begin
    if (!waveOn) begin
      sqWave  <= waveLevel;
      halfCnt <= 0;
    end else if (halfCnt == halfPer - 1) begin
      sqWave  <= ~sqWave;
      halfCnt <= 0;
    end else begin
      halfCnt <= halfCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitDone(input int limit, output int cyc, output bit seen);
    seen = 1'b0;
    cyc  = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        cyc  = i;
        break;
      end
    end
  endtask

  task automatic testReset();
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(fail == 1'b0, "R1", "fail after reset", fail, 0);
    check(period == '0, "R1", "period after reset", period, 0);
  endtask

  // Measurement with wave half period h: elapsed = 8*2h ticks, period = 16h >> 1 = 8h
  task automatic runMeas(input int h, input int expP, input bit expFail, input string req);
    int  cyc;
    bit  seen;
    halfPer   = h;
    waveLevel = 1'b0;
    waveOn    = 1'b1;
    pulseStart();
    check(busy == 1'b1 && fail == 1'b0, "R2", "busy/!fail after start", {busy, fail}, 2);
    waitDone(4000, cyc, seen);
    check(seen, req, "done seen", seen, 1);
    check(period == PW'(expP), req, "period", period, expP);
    check(fail == expFail, req, "fail flag", fail, expFail);
    check(busy == 1'b0, "R8", "busy low with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R8", "done single cycle", done, 0);
    waveOn = 1'b0;
  endtask

  // No edges: done exactly TO_CYC cycles after the start edge, default result
  task automatic runTimeout(input bit level, input string req);
    int cyc;
    bit seen;
    waveOn    = 1'b0;
    waveLevel = level;
    repeat (4) @(negedge clk);
    pulseStart();
    waitDone(TO_CYC + 20, cyc, seen);
    check(seen && cyc == TO_CYC, req, "timeout cycle", cyc, TO_CYC);
    check(fail == 1'b1, req, "timeout fail", fail, 1);
    check(period == PW'(EXP_DEF), req, "timeout period", period, EXP_DEF);
    waveLevel = 1'b0;
  endtask

  task automatic testSticky();
    runMeas(4, EXP_DEF, 1'b1, "R7");
    repeat (15) @(negedge clk);
    check(fail == 1'b1, "R10", "fail held while idle", fail, 1);
    check(period == PW'(EXP_DEF), "R10", "period held while idle", period, EXP_DEF);
    runMeas(8, 64, 1'b0, "R2"); // start clears the sticky fail
  endtask

  initial begin
    #(5 * 150_000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runMeas(8, 64, 1'b0, "R4");          // R4/R5: 8-cycle window after 2 skipped edges, 50 MHz
    runMeas(6, 48, 1'b0, "R5");          // R5: 66.7 MHz
    runMeas(16, EXP_SLOW, 1'b0, "R6");   // R6: exactly on the slow bound, still passes
    runMeas(17, EXP_DEF, 1'b1, "R7");    // R7: slower than 25 MHz
    runMeas(5, EXP_DEF, 1'b1, "R7");     // R7: period 40 below fast bound 42
    testSticky();                        // R10 then R2
    runTimeout(1'b0, "R9");              // R9: wave stuck low
    runTimeout(1'b1, "R3");              // R3: wave high at start is not an edge
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule